// File: doc/BRIEF.md
# Masked Component Register File

This block is the register bank for the cache/memory register region of a coherent-link component. A simple request port (valid, write flag, byte address, byte size, write data) reaches a top-level capability header word, a table of sub-capability headers, a RAS error register group and one host-managed memory decoder. Every writable register has its own write mask. A write merges through that mask, so bits outside it never change.

The elaboration parameter `COMP_KIND` picks the component kind: 0 downstream port, 1 plain device, 2 upstream port, 3 type-3 device, 4 logical device, 5 root port. The kind sets how many capabilities are advertised and which sub-headers are populated. It decides whether the decoder registers exist and sets one decoder write mask. Writing the commit bit of the decoder control register stores a committed status instead of a pending request.

Top module: `cmreg_bank`

## Requirements
- R1: Offset 0x00 reads as a constant header: bits [15:0]=1, [19:16]=1, [23:20]=1, and [31:24] equal to the capability count. The count is 2 for kinds 0 and 1, 3 for kinds 2, 3 and 4, and 5 for kind 5. Writes to this offset have no effect.
- R2: Offsets 0x04, 0x08, 0x0C, 0x10 and 0x14 hold the sub-headers of slots 0 to 4, encoded as ID [15:0], version [19:16] and pointer [31:20]. The slots are RAS (ID 2, version 2, pointer 0x040), link (ID 4, version 2, pointer 0x080), decoder (ID 5, version 1, pointer 0x0C0), extended security (ID 6, version 1, pointer 0x100) and snoop (ID 8, version 1, pointer 0x140). A slot whose index is not below the capability count reads zero.
- R3: A 32-bit write stores (wdata AND mask) OR (old AND NOT mask).
- R4: Uncorrectable mask (0x44) and severity (0x48) reset to 0x1CFFF with write mask 0x1CFFF. Correctable mask (0x50) resets to 0x7F with write mask 0x7F. Uncorrectable status (0x40), correctable status (0x4C) and capability/control (0x54) always read zero.
- R5: Decoder capability (0xC0) reads 0x310 and is read-only: decoder-count code 0 in [3:0], target count 1 in [7:4], 256-byte interleave in bit 8, 4 KiB interleave in bit 9, no poison in bit 10. Global control (0xC4) resets to 0 with write mask 0x3.
- R6: Decoder registers reset to 0. Write masks: base low (0xD0) and size low (0xD8) 0xF0000000; base high (0xD4), size high (0xDC) and target list high (0xE8) 0xFFFFFFFF; control (0xE0) 0x13FF.
- R7: Target list low (0xE4) has write mask 0xF0000000 for kinds 1, 3 and 4, and 0xFFFFFFFF for the port kinds 0, 2 and 5.
- R8: A control write whose bit 9 (commit) is set stores bit 9=0, bit 11 (error)=0 and bit 10 (committed)=1. A later control write without commit keeps bit 10.
- R9: When the capability count is below 3, offsets 0xC0 to 0xE8 read zero and drop writes.
- R10: Only accesses with size 4 take effect. Any other size reads zero and its write is ignored.
- R11: Offsets that map no register read zero and drop writes. The low two address bits are ignored.
- R12: A read request raises rvalid and presents rdata on the next clock edge, and rvalid is low after any other cycle. A synchronous reset restores every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the region |
| req_size | input | 4 | Access size in bytes; only 4 is honoured |
| req_wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 32 | Registered read data |

## Verification
The checker watches the request port on every cycle. It confirms the read handshake latency, the zero result of non-32-bit and unmapped reads, the constant top-level header for the configured kind, and the always-zero status registers. The merge through write masks, the target-list mask that depends on the kind, the commit-to-committed conversion and the restore on a second reset are all stateful. Only the bench's write-then-read scenarios show them, and it runs those on a type-3 device, a root port and a downstream port side by side.

// File: rtl/cmreg_pkg.sv
`timescale 1ns/1ps
package cmreg_pkg;

   localparam int KIND_DSP = 0;
   localparam int KIND_DEV = 1;
   localparam int KIND_USP = 2;
   localparam int KIND_T3  = 3;
   localparam int KIND_LD  = 4;
   localparam int KIND_RP  = 5;

   localparam int DW       = 32;
   localparam int NUM_SLOT = 5;

   // decoder control bit positions
   localparam int CTL_COMMIT    = 9;
   localparam int CTL_COMMITTED = 10;
   localparam int CTL_ERROR     = 11;
   localparam logic [DW-1:0] CTL_MASK = 32'h0000_13FF;
   localparam logic [DW-1:0] DEC_CAP  = 32'h0000_0310;

   // byte offsets
   localparam int OFF_TOP     = 'h00;
   localparam int OFF_SLOT0   = 'h04;
   localparam int OFF_UNC_ST  = 'h40;
   localparam int OFF_COR_ST  = 'h4C;
   localparam int OFF_RAS_CAP = 'h54;
   localparam int OFF_DEC_CAP = 'hC0;
   localparam int OFF_DEC_CTL = 'hE0;

   localparam int RAS_N = 3;
   localparam int DEC_N = 7;

   function automatic int cap_count(input int kind);
      case (kind)
         KIND_DSP, KIND_DEV:         return 2;
         KIND_USP, KIND_T3, KIND_LD: return 3;
         default:                    return 5;
      endcase
   endfunction

   function automatic bit is_device(input int kind);
      return (kind == KIND_DEV) || (kind == KIND_T3) || (kind == KIND_LD);
   endfunction

   function automatic logic [DW-1:0] top_header(input int kind);
      logic [7:0] cnt;
      cnt = 8'(cap_count(kind));
      return {cnt, 4'd1, 4'd1, 16'd1};
   endfunction

   function automatic logic [DW-1:0] slot_header(input int idx);
      logic [11:0] ptr;
      logic [3:0]  ver;
      logic [15:0] id;
      case (idx)
         0:       begin id = 16'd2; ver = 4'd2; ptr = 12'h040; end
         1:       begin id = 16'd4; ver = 4'd2; ptr = 12'h080; end
         2:       begin id = 16'd5; ver = 4'd1; ptr = 12'h0C0; end
         3:       begin id = 16'd6; ver = 4'd1; ptr = 12'h100; end
         default: begin id = 16'd8; ver = 4'd1; ptr = 12'h140; end
      endcase
      return {ptr, ver, id};
   endfunction

   // RAS writable group: 0 uncorrectable mask, 1 severity, 2 correctable mask
   function automatic int ras_off(input int i);
      case (i)
         0:       return 'h44;
         1:       return 'h48;
         default: return 'h50;
      endcase
   endfunction

   function automatic logic [DW-1:0] ras_mask(input int i);
      return (i == 2) ? 32'h0000_007F : 32'h0001_CFFF;
   endfunction

   // decoder plain masked registers (control handled separately)
   function automatic int dec_off(input int i);
      case (i)
         0:       return 'hC4;
         1:       return 'hD0;
         2:       return 'hD4;
         3:       return 'hD8;
         4:       return 'hDC;
         5:       return 'hE4;
         default: return 'hE8;
      endcase
   endfunction

   function automatic logic [DW-1:0] dec_mask(input int i, input bit dev);
      case (i)
         0:       return 32'h0000_0003;
         1, 3:    return 32'hF000_0000;
         5:       return dev ? 32'hF000_0000 : 32'hFFFF_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/cmreg_mreg.sv
`timescale 1ns/1ps
module cmreg_mreg #(
   parameter int              W    = 32,
   parameter logic [W-1:0]    RST  = '0,
   parameter logic [W-1:0]    MASK = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= RST;
      else if (we) q <= (wdata & MASK) | (q & ~MASK);
   end
endmodule

// File: rtl/cmreg_ras.sv
`timescale 1ns/1ps
module cmreg_ras
   import cmreg_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rd
);
   logic [DW-1:0] q   [RAS_N];
   logic [RAS_N-1:0] sel;

   for (genvar g = 0; g < RAS_N; g++) begin : g_reg
      localparam logic [DW-1:0] M = ras_mask(g);
      assign sel[g] = (idx == IDX_W'(ras_off(g) >> 2));
      cmreg_mreg #(.W(DW), .RST(M), .MASK(M)) u_reg (
         .clk(clk), .rst(rst), .we(we && sel[g]), .wdata(wdata), .q(q[g])
      );
   end

   // status and capability words read zero; only the writable group returns data
   always_comb begin
      rd = '0;
      for (int i = 0; i < RAS_N; i++)
         if (sel[i]) rd = q[i];
   end
endmodule

// File: rtl/cmreg_dec.sv
`timescale 1ns/1ps
module cmreg_dec
   import cmreg_pkg::*;
#(
   parameter int IDX_W   = 10,
   parameter bit DEV_TGT = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rd
);
   localparam logic [IDX_W-1:0] CTL_IDX = IDX_W'(OFF_DEC_CTL >> 2);
   localparam logic [IDX_W-1:0] CAP_IDX = IDX_W'(OFF_DEC_CAP >> 2);

   logic [DW-1:0]    q [DEC_N];
   logic [DEC_N-1:0] sel;
   logic [DW-1:0]    ctl_q, ctl_merge;

   for (genvar g = 0; g < DEC_N; g++) begin : g_reg
      assign sel[g] = (idx == IDX_W'(dec_off(g) >> 2));
      cmreg_mreg #(.W(DW), .RST('0), .MASK(dec_mask(g, DEV_TGT))) u_reg (
         .clk(clk), .rst(rst), .we(we && sel[g]), .wdata(wdata), .q(q[g])
      );
   end

   always_comb begin
      ctl_merge = (wdata & CTL_MASK) | (ctl_q & ~CTL_MASK);
      if (ctl_merge[CTL_COMMIT]) begin
         ctl_merge[CTL_COMMIT]    = 1'b0;
         ctl_merge[CTL_ERROR]     = 1'b0;
         ctl_merge[CTL_COMMITTED] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                          ctl_q <= '0;
      else if (we && idx == CTL_IDX)    ctl_q <= ctl_merge;
   end

   always_comb begin
      rd = '0;
      if (idx == CAP_IDX) rd = DEC_CAP;
      if (idx == CTL_IDX) rd = ctl_q;
      for (int i = 0; i < DEC_N; i++)
         if (sel[i]) rd = q[i];
   end
endmodule

// File: rtl/cmreg_bank.sv
`timescale 1ns/1ps
module cmreg_bank
   import cmreg_pkg::*;
#(
   parameter int COMP_KIND = KIND_T3,
   parameter int ADDR_W    = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              rvalid,
   output logic [31:0]       rdata
);
   localparam int  IDX_W   = ADDR_W - 2;
   localparam int  NCAP    = cap_count(COMP_KIND);
   localparam bit  HAS_DEC = (NCAP >= 3);
   localparam logic [IDX_W-1:0] SLOT_LO = IDX_W'(OFF_SLOT0 >> 2);

   if (ADDR_W < 10 || ADDR_W > 32) begin : g_bad_addr
      $error("cmreg_bank: ADDR_W must lie in 10..32");
   end
   if (COMP_KIND < KIND_DSP || COMP_KIND > KIND_RP) begin : g_bad_kind
      $error("cmreg_bank: COMP_KIND out of range");
   end

   logic [IDX_W-1:0] idx;
   logic             word_ok, wr_en, rd_req;
   logic [DW-1:0]    hdr_rd, ras_rd, dec_rd, rd_mux;

   assign idx     = req_addr[ADDR_W-1:2];
   assign word_ok = (req_size == 4'd4);
   assign wr_en   = req_valid && req_write && word_ok;
   assign rd_req  = req_valid && !req_write;

   // header table: top word plus populated slots
   always_comb begin
      hdr_rd = '0;
      if (idx == IDX_W'(OFF_TOP >> 2)) hdr_rd = top_header(COMP_KIND);
      for (int s = 0; s < NUM_SLOT; s++)
         if (s < NCAP && idx == SLOT_LO + IDX_W'(s)) hdr_rd = slot_header(s);
   end

   cmreg_ras #(.IDX_W(IDX_W)) u_ras (
      .clk(clk), .rst(rst), .we(wr_en), .idx(idx), .wdata(req_wdata), .rd(ras_rd)
   );

   if (HAS_DEC) begin : g_dec
      cmreg_dec #(.IDX_W(IDX_W), .DEV_TGT(is_device(COMP_KIND))) u_dec (
         .clk(clk), .rst(rst), .we(wr_en), .idx(idx), .wdata(req_wdata), .rd(dec_rd)
      );
   end else begin : g_no_dec
      assign dec_rd = '0;
   end

   // regions do not overlap, so OR-combining is a mux
   assign rd_mux = hdr_rd | ras_rd | dec_rd;

   always_ff @(posedge clk) begin
      if (rst) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd_req;
         if (rd_req) rdata <= word_ok ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/cmreg_bank_chk.sv
`timescale 1ns/1ps
module cmreg_bank_chk #(
   parameter int COMP_KIND = 3,
   parameter int ADDR_W    = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [3:0]        req_size,
   input logic              rvalid,
   input logic [31:0]       rdata
);
   localparam logic [7:0] EXP_CNT = (COMP_KIND <= 1) ? 8'd2 : (COMP_KIND <= 4) ? 8'd3 : 8'd5;
   localparam logic [31:0] EXP_TOP = {EXP_CNT, 24'h11_0001};

   logic rd32, rd;
   assign rd   = req_valid && !req_write;
   assign rd32 = rd && req_size == 4'd4;

   assert_rvalid_R12: assert property (@(posedge clk) disable iff (rst)
      rd |=> rvalid);
   assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
      !rd |=> !rvalid);
   assert_wide_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (rd && req_size != 4'd4) |=> (rdata == 32'd0));
   assert_top_hdr_R1: assert property (@(posedge clk) disable iff (rst)
      (rd32 && req_addr[ADDR_W-1:2] == '0) |=> (rdata == EXP_TOP));
   assert_status_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (rd32 && (req_addr[7:2] == 6'h10 || req_addr[7:2] == 6'h13) && req_addr[ADDR_W-1:8] == '0)
      |=> (rdata == 32'd0));
   assert_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
      (rd && req_addr[ADDR_W-1:8] != '0) |=> (rdata == 32'd0));
endmodule

bind cmreg_bank cmreg_bank_chk #(.COMP_KIND(COMP_KIND), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cmreg_bank_bench.sv
`timescale 1ns/1ps
module cmreg_bank_bench;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0]    req_size = 4'd4;
   logic [31:0]   req_wdata = '0;
   logic          rv_t3, rv_rp, rv_dsp;
   logic [31:0]   rd_t3, rd_rp, rd_dsp;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cmreg_bank #(.COMP_KIND(3), .ADDR_W(AW)) u_cmreg_bank (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rvalid(rv_t3), .rdata(rd_t3));
   cmreg_bank #(.COMP_KIND(5), .ADDR_W(AW)) u_rp (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rvalid(rv_rp), .rdata(rd_rp));
   cmreg_bank #(.COMP_KIND(0), .ADDR_W(AW)) u_dsp (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rvalid(rv_dsp), .rdata(rd_dsp));

   // columns: addr, wdata, expected type-3, expected root port, expected downstream port, tag
   localparam int NV = 20;
   localparam logic [31:0] VEC [0:NV-1][0:5] = '{
      '{32'h44, 32'hFFFF_FFFF, 32'h0001_CFFF, 32'h0001_CFFF, 32'h0001_CFFF, 3},
      '{32'h44, 32'h0000_0000, 32'h0,         32'h0,         32'h0,         3},
      '{32'h48, 32'h0001_2345, 32'h0001_0345, 32'h0001_0345, 32'h0001_0345, 4},
      '{32'h50, 32'hFFFF_FF80, 32'h0,         32'h0,         32'h0,         4},
      '{32'h40, 32'hFFFF_FFFF, 32'h0,         32'h0,         32'h0,         4},
      '{32'h4C, 32'hFFFF_FFFF, 32'h0,         32'h0,         32'h0,         4},
      '{32'h54, 32'hFFFF_FFFF, 32'h0,         32'h0,         32'h0,         4},
      '{32'hC4, 32'hFFFF_FFFF, 32'h3,         32'h3,         32'h0,         5},
      '{32'hC0, 32'hFFFF_FFFF, 32'h310,       32'h310,       32'h0,         5},
      '{32'hD0, 32'hFFFF_FFFF, 32'hF000_0000, 32'hF000_0000, 32'h0,         6},
      '{32'hD4, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'h0,         6},
      '{32'hD8, 32'h1234_ABCD, 32'h1000_0000, 32'h1000_0000, 32'h0,         6},
      '{32'hDC, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         6},
      '{32'hE8, 32'h0F0F_0F0F, 32'h0F0F_0F0F, 32'h0F0F_0F0F, 32'h0,         6},
      '{32'hE4, 32'hFFFF_FFFF, 32'hF000_0000, 32'hFFFF_FFFF, 32'h0,         7},
      '{32'hE0, 32'h0000_13FF, 32'h0000_15FF, 32'h0000_15FF, 32'h0,         8},
      '{32'hE0, 32'h0000_0005, 32'h0000_0405, 32'h0000_0405, 32'h0,         8},
      '{32'h04, 32'hFFFF_FFFF, 32'h0402_0002, 32'h0402_0002, 32'h0402_0002, 2},
      '{32'h00, 32'h0000_0000, 32'h0311_0001, 32'h0511_0001, 32'h0211_0001, 1},
      '{32'h14, 32'h0000_0000, 32'h0,         32'h1401_0008, 32'h0,         2}
   };

   function automatic string tag_name(input logic [31:0] t);
      case (t)
         1: return "R1";  2: return "R2";  3: return "R3";
         4: return "R4";  5: return "R5";  6: return "R6";
         7: return "R7";  default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] sz);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d; req_size = sz;
      @(negedge clk);
      req_valid = 0; req_write = 0; req_size = 4'd4;
   endtask

   task automatic bus_read(input logic [31:0] a, input logic [3:0] sz);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = AW'(a); req_size = sz;
      @(negedge clk);
      req_valid = 0; req_size = 4'd4;
   endtask

   task automatic read3(input string req, input logic [31:0] a, input logic [31:0] e3,
                        input logic [31:0] erp, input logic [31:0] edsp);
      bus_read(a, 4'd4);
      check(req, $sformatf("t3 @%0h", a), rd_t3, e3);
      check(req, $sformatf("rp @%0h", a), rd_rp, erp);
      check(req, $sformatf("dsp @%0h", a), rd_dsp, edsp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      check("R12", "rvalid after reset", 32'(rv_t3), 32'd0);

      // reset values (R4, R5, R2, R1)
      read3("R4", 32'h44, 32'h1CFFF, 32'h1CFFF, 32'h1CFFF);
      read3("R4", 32'h50, 32'h7F, 32'h7F, 32'h7F);
      read3("R5", 32'hC4, 32'h0, 32'h0, 32'h0);
      read3("R2", 32'h10, 32'h0, 32'h1001_0006, 32'h0);
      read3("R2", 32'h0C, 32'h0C01_0005, 32'h0C01_0005, 32'h0);
      read3("R1", 32'h00, 32'h0311_0001, 32'h0511_0001, 32'h0211_0001);

      // R10: wide accesses
      bus_write(32'h44, 32'h0, 4'd8);
      read3("R10", 32'h44, 32'h1CFFF, 32'h1CFFF, 32'h1CFFF);
      bus_read(32'h00, 4'd8);
      check("R10", "wide read t3", rd_t3, 32'h0);
      check("R10", "wide read rp", rd_rp, 32'h0);

      // R11: unmapped offsets, low address bits ignored
      bus_write(32'h300, 32'hFFFF_FFFF, 4'd4);
      read3("R11", 32'h300, 32'h0, 32'h0, 32'h0);
      read3("R11", 32'h51, 32'h7F, 32'h7F, 32'h7F);

      // R12: handshake
      bus_read(32'h00, 4'd4);
      check("R12", "rvalid after read", 32'(rv_t3), 32'd1);
      @(negedge clk);
      check("R12", "rvalid idle", 32'(rv_t3), 32'd0);

      // R9: decoder region absent on downstream port
      bus_write(32'hD4, 32'h1234_5678, 4'd4);
      read3("R9", 32'hD4, 32'h1234_5678, 32'h1234_5678, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i][0], VEC[i][1], 4'd4);
         read3(tag_name(VEC[i][5]), VEC[i][0], VEC[i][2], VEC[i][3], VEC[i][4]);
      end

      // R12: second reset restores values
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      read3("R12", 32'h44, 32'h1CFFF, 32'h1CFFF, 32'h1CFFF);
      read3("R12", 32'hE0, 32'h0, 32'h0, 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule